// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block gathers a set of level-sensitive interrupt inputs, organised in banks of 32, behind a 32-bit word-addressed register bus. It drives one request line toward a processor. Each bank has a mask word. Software can write the mask directly, or change it through two alias addresses: one clears the bits written as one, and the other sets them. A pending word per bank shows which sources are both asserted and enabled.

When no interrupt is held, the controller picks the lowest-numbered pending source. It latches that number into an active register and raises the request line. The number stays frozen until software writes an acknowledge to the control register. The acknowledge is always honoured, including when the latched source has since been masked or has gone away, so a stale selection cannot keep the line high.

Other registers:
- A system configuration register holds an autoidle bit and a self-clearing soft-reset bit.
- A status bit reports when the soft reset has finished.
- A fixed revision word can be read.
- Per-source level registers, a protection word, an idle word and a threshold word are plain storage that software can save and restore.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every mask bit is 1, `irq_o` is 0, the active register (0x40) reads 0 and bit 0 of the status register (0x14) reads 1.
- R2: Writing to 0x88 + 0x20*n clears the mask bits of bank n where the written data has ones, and leaves the rest unchanged. The mask of bank n reads, and can be written directly, at 0x84 + 0x20*n.
- R3: Writing to 0x8C + 0x20*n sets the mask bits of bank n where the written data has ones, and leaves the rest unchanged. A write of all zeros has no effect.
- R4: The pending word of bank n at 0x98 + 0x20*n reads as the bank's 32 inputs ANDed with the inverse of its mask. Source number 32*n + k is bit k of bank n.
- R5: When nothing is held and at least one source is pending, the controller latches the lowest-numbered pending source on the next clock edge. `irq_o` is 1 from that edge on, and 0x40 returns the number in bits 6:0.
- R6: While a selection is held, the active number and `irq_o` stay unchanged, even if a lower-numbered source becomes pending.
- R7: A write to 0x48 with bit 0 set drops `irq_o` on that edge and clears the active register to 0. If anything is still pending, a new selection is made one edge later. A write to 0x48 with bit 0 clear changes nothing.
- R8: The acknowledge is accepted when the held source has already been masked. `irq_o` then stays 0 while nothing is pending.
- R9: Writing 0x10 with bit 1 set starts a soft reset lasting RST_CYCLES cycles. During the reset, status bit 0 reads 0, bit 1 of 0x10 reads 1 and bus writes are ignored. Afterwards every register is back at its reset value and status bit 0 reads 1.
- R10: Bit 0 of 0x10 (autoidle) reads back the value last written by a write that did not start a soft reset.
- R11: The register at 0x00 returns REV_MAJOR in bits 7:4 and REV_MINOR in bits 3:0.
- R12: The level register of source i at 0x100 + 4*i stores the low LVL_W bits of the written data, and its upper bits read 0. The registers at 0x4C, 0x50 and 0x68 store all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NUM_BANKS*32 | Level interrupt inputs, synchronous to clk |
| bus_wr | input | 1 | Write strobe, committed on the rising edge |
| bus_addr | input | ADDR_W | Byte address of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Interrupt request, high while a selection is held |

## Verification
Two enabled sources are raised together to show that the lower number wins. A lower source is then enabled while a higher one is held, to separate a frozen selection from one that is recomputed every cycle. A source in the third bank checks that the bank offset is added into the active number. A selected source is masked before the acknowledge, so a controller that requires a live source to acknowledge would leave the request line high. Zero-data alias writes and an acknowledge with bit 0 clear show that zero bits do nothing.

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
  parameter int         NUM_BANKS  = 3,
  parameter int         LVL_W      = 8,
  parameter int         RST_CYCLES = 4,
  parameter int         ADDR_W     = 10,
  parameter logic [3:0] REV_MAJOR  = 4'h2,
  parameter logic [3:0] REV_MINOR  = 4'h1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_BANKS*32-1:0]   irq_src,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic                      irq_o
);
  localparam int NSRC   = NUM_BANKS * 32;
  localparam int NUM_W  = 7;
  localparam int CNT_W  = $clog2(RST_CYCLES + 1);
  localparam int STRIDE = 32;
  localparam int LVL_END = 256 + 4 * NSRC;
  localparam logic [ADDR_W-1:0] A_REV    = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] A_SYSCFG = ADDR_W'(12'h010);
  localparam logic [ADDR_W-1:0] A_SYSST  = ADDR_W'(12'h014);
  localparam logic [ADDR_W-1:0] A_ACTIVE = ADDR_W'(12'h040);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(12'h048);
  localparam logic [ADDR_W-1:0] A_PROT   = ADDR_W'(12'h04C);
  localparam logic [ADDR_W-1:0] A_IDLE   = ADDR_W'(12'h050);
  localparam logic [ADDR_W-1:0] A_THRESH = ADDR_W'(12'h068);
  localparam logic [ADDR_W-1:0] A_LVL    = ADDR_W'(12'h100);
  localparam int B_MASK = 'h84;
  localparam int B_MCLR = 'h88;
  localparam int B_MSET = 'h8C;
  localparam int B_PEND = 'h98;
  localparam logic [NSRC-1:0] ONE = NSRC'(1);

  function automatic logic [ADDR_W-1:0] bank_addr(input int base, input int b);
    return ADDR_W'(base + b * STRIDE);
  endfunction

  logic [NUM_BANKS-1:0][31:0] mask, pend;
  logic [NSRC-1:0]            pend_flat;
  logic [NSRC-1:0][LVL_W-1:0] lvl;
  logic [31:0]                prot, idle, thresh;
  logic                       autoidle, held;
  logic [NUM_W-1:0]           act, low_idx;
  logic [CNT_W-1:0]           srst_cnt;
  logic                       busy, wr_ok, ack_w, srst_w, lvl_hit;
  logic [ADDR_W-1:0]          lvl_off;
  logic [NUM_W-1:0]           lvl_idx;

  assign busy    = (srst_cnt != '0);
  assign wr_ok   = bus_wr && !busy;
  assign ack_w   = wr_ok && (bus_addr == A_CTRL) && bus_wdata[0];
  assign srst_w  = wr_ok && (bus_addr == A_SYSCFG) && bus_wdata[1];
  assign lvl_hit = (bus_addr >= A_LVL) && (int'(bus_addr) < LVL_END);
  assign lvl_off = bus_addr - A_LVL;
  assign lvl_idx = lvl_off[NUM_W+1:2];
  assign irq_o   = held;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_pend
    assign pend[b] = irq_src[b*32 +: 32] & ~mask[b];
  end
  assign pend_flat = pend;

  always_comb begin
    low_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend_flat[i]) low_idx = NUM_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srst_cnt <= '0;
    else if (busy) srst_cnt <= srst_cnt - 1'b1;
    else if (srst_w) srst_cnt <= CNT_W'(RST_CYCLES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
      act  <= '0;
    end else if (busy) begin
      held <= 1'b0;
      act  <= '0;
    end else if (ack_w) begin
      held <= 1'b0;
      act  <= '0;
    end else if (!held && |pend_flat) begin
      held <= 1'b1;
      act  <= low_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask     <= '1;
      autoidle <= 1'b0;
      prot     <= '0;
      idle     <= '0;
      thresh   <= '0;
      lvl      <= '0;
    end else if (busy) begin
      mask     <= '1;
      autoidle <= 1'b0;
      prot     <= '0;
      idle     <= '0;
      thresh   <= '0;
      lvl      <= '0;
    end else if (wr_ok) begin
      if (bus_addr == A_SYSCFG) autoidle <= bus_wdata[1] ? 1'b0 : bus_wdata[0];
      if (bus_addr == A_PROT)   prot   <= bus_wdata;
      if (bus_addr == A_IDLE)   idle   <= bus_wdata;
      if (bus_addr == A_THRESH) thresh <= bus_wdata;
      if (lvl_hit) lvl[lvl_idx] <= bus_wdata[LVL_W-1:0];
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bus_addr == bank_addr(B_MASK, b)) mask[b] <= bus_wdata;
        if (bus_addr == bank_addr(B_MCLR, b)) mask[b] <= mask[b] & ~bus_wdata;
        if (bus_addr == bank_addr(B_MSET, b)) mask[b] <= mask[b] | bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_REV:    bus_rdata = {24'b0, REV_MAJOR, REV_MINOR};
      A_SYSCFG: bus_rdata = {30'b0, busy, autoidle};
      A_SYSST:  bus_rdata = {31'b0, !busy};
      A_ACTIVE: bus_rdata = {{(32-NUM_W){1'b0}}, act};
      A_PROT:   bus_rdata = prot;
      A_IDLE:   bus_rdata = idle;
      A_THRESH: bus_rdata = thresh;
      default:  bus_rdata = '0;
    endcase
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_addr == bank_addr(B_MASK, b)) bus_rdata = mask[b];
      if (bus_addr == bank_addr(B_PEND, b)) bus_rdata = pend[b];
    end
    if (lvl_hit) bus_rdata = 32'(lvl[lvl_idx]);
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    held && !ack_w && !busy |=> held && $stable(act)); // R6
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_w |=> !irq_o); // R7
  AST_SELECT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    !held && (|pend_flat) && !busy && !ack_w |=> irq_o); // R5
  AST_PICK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> (($past(pend_flat) & (ONE << act)) != '0)); // R5
  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> (($past(pend_flat) & ((ONE << act) - ONE)) == '0)); // R5
  AST_SRST_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (&mask) && !irq_o); // R9

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok && bus_addr == bank_addr(B_MSET, b)
        |=> (mask[b] & $past(bus_wdata)) == $past(bus_wdata)); // R3
    AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok && bus_addr == bank_addr(B_MCLR, b)
        |=> (mask[b] & $past(bus_wdata)) == '0); // R2
  end
endmodule

// File: tb/sim_banked_irq_ctrl.sv
module sim_banked_irq_ctrl;
  localparam int NB = 3;
  localparam int RC = 4;
  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [95:0] irq_src = '0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, d;
  logic        irq_o;
  int total = 0, bad = 0;

  banked_irq_ctrl #(.NUM_BANKS(NB), .RST_CYCLES(RC)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic wr(input logic [9:0] a, input logic [31:0] v);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = v;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic rd(input logic [9:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic t_reset();
    rd(10'h084, d); check("R1 mask0", d, 32'hFFFFFFFF);
    rd(10'h0C4, d); check("R1 mask2", d, 32'hFFFFFFFF);
    rd(10'h040, d); check("R1 active", d, 0);
    rd(10'h014, d); check("R1 status", d, 1);
    check("R1 irq", 32'(irq_o), 0);
    rd(10'h000, d); check("R11 revision", d, 32'h21);
  endtask

  task automatic t_mask();
    wr(10'h088, 32'h000000F0); rd(10'h084, d); check("R2 clear", d, 32'hFFFFFF0F);
    wr(10'h08C, 32'h00000010); rd(10'h084, d); check("R3 set", d, 32'hFFFFFF1F);
    wr(10'h08C, 32'h0); rd(10'h084, d); check("R3 zero set ignored", d, 32'hFFFFFF1F);
    wr(10'h088, 32'h0); rd(10'h084, d); check("R2 zero clear ignored", d, 32'hFFFFFF1F);
    wr(10'h0A8, 32'h1); rd(10'h0A4, d); check("R2 bank1 clear", d, 32'hFFFFFFFE);
    rd(10'h084, d); check("R2 bank0 untouched", d, 32'hFFFFFF1F);
    wr(10'h084, 32'hFFFFFFFF); wr(10'h0AC, 32'h1);
    rd(10'h0A4, d); check("R2 direct write and set", d, 32'hFFFFFFFF);
    check("R3 no irq", 32'(irq_o), 0);
  endtask

  task automatic t_select();
    irq_src = '0; irq_src[5] = 1; irq_src[6] = 1; irq_src[67] = 1;
    wr(10'h088, 32'h40);
    check("R5 not yet", 32'(irq_o), 0);
    tick(); check("R5 irq raised", 32'(irq_o), 1);
    rd(10'h098, d); check("R4 pend0", d, 32'h40);
    rd(10'h0D8, d); check("R4 pend2 masked", d, 0);
    rd(10'h040, d); check("R5 active", d, 6);
    wr(10'h088, 32'h20);
    rd(10'h098, d); check("R4 pend0 two", d, 32'h60);
    rd(10'h040, d); check("R6 held despite lower", d, 6);
    wr(10'h048, 32'h1);
    check("R7 ack drops", 32'(irq_o), 0);
    rd(10'h040, d); check("R7 reselect lowest", d, 5);
    check("R7 irq again", 32'(irq_o), 1);
    wr(10'h048, 32'h2);
    rd(10'h040, d); check("R7 bit0 clear ignored", d, 5);
    check("R7 irq kept", 32'(irq_o), 1);
  endtask

  task automatic t_stale();
    wr(10'h08C, 32'h60);
    check("R8 still held", 32'(irq_o), 1);
    wr(10'h048, 32'h1);
    tick(); tick();
    check("R8 stale ack", 32'(irq_o), 0);
    rd(10'h040, d); check("R8 active zero", d, 0);
  endtask

  task automatic t_bank2();
    wr(10'h0C8, 32'h8);
    rd(10'h0D8, d); check("R4 pend2", d, 32'h8);
    rd(10'h040, d); check("R5 bank2 number", d, 67);
    wr(10'h0CC, 32'h8); wr(10'h048, 32'h1);
    tick(); check("R7 bank2 acked", 32'(irq_o), 0);
  endtask

  task automatic t_store_and_srst();
    wr(10'h010, 32'h1); rd(10'h010, d); check("R10 autoidle", d, 1);
    wr(10'h04C, 32'hDEADBEEF); rd(10'h04C, d); check("R12 protection", d, 32'hDEADBEEF);
    wr(10'h050, 32'h12345678); rd(10'h050, d); check("R12 idle", d, 32'h12345678);
    wr(10'h068, 32'hFF);       rd(10'h068, d); check("R12 threshold", d, 32'hFF);
    wr(10'h27C, 32'hABC);      rd(10'h27C, d); check("R12 level 95", d, 32'hBC);
    wr(10'h100, 32'h5A);       rd(10'h100, d); check("R12 level 0", d, 32'h5A);
    irq_src[32] = 1; wr(10'h0A8, 32'h1); tick();
    check("R9 pre irq", 32'(irq_o), 1);
    wr(10'h010, 32'h2);
    rd(10'h014, d); check("R9 busy status", d, 0);
    rd(10'h010, d); check("R9 busy bit", d, 2);
    wr(10'h04C, 32'h1);
    for (int i = 0; i < RC; i++) tick();
    rd(10'h014, d); check("R9 done", d, 1);
    rd(10'h0A4, d); check("R9 mask1 reset", d, 32'hFFFFFFFF);
    rd(10'h04C, d); check("R9 protection reset", d, 0);
    rd(10'h27C, d); check("R9 level reset", d, 0);
    rd(10'h010, d); check("R9 sysconfig reset", d, 0);
    rd(10'h040, d); check("R9 active reset", d, 0);
    check("R9 irq reset", 32'(irq_o), 0);
  endtask

  initial begin
    #20 rst_n = 1;
    t_reset();
    t_mask();
    t_select();
    t_stale();
    t_bank2();
    t_store_and_srst();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule